// File: doc/BRIEF.md
# Counter-array timebase and control

This block is the shared timebase of a programmable counter array in an 8-bit microcontroller. A free-running up-counter advances on a count pulse taken from one of four sources: two prescaled fractions of the oscillator, whose ratios depend on whether the core runs in 12-clock or 6-clock mode, the timer-0 overflow strobe, or an external pin. The external pin is first passed through a two-flop synchronizer. Counting needs the run bit. When the idle-control bit is set, counting also stops while the core is idle.

Two byte-wide registers are written over a simple strobe interface and are always visible on read ports. The mode register holds the idle control, the watchdog enable handed to module 4, the source select and the overflow interrupt enable. The control/status register holds the sticky overflow flag, the run bit and the five per-module event flags. Hardware sets the flags and software may also set them. Only a software write clears them. One interrupt line combines the enabled overflow flag with the module flags.

Top module: `pca_timebase`

## Requirements
- R1: After reset, both register read ports, the count, the interrupt and the watchdog enable are all 0.
- R2: Mode register layout: bit 7 idle control, bit 6 watchdog enable (driven on `wdog_en_o`), bits 2:1 source select, bit 0 overflow interrupt enable. Bits 5:3 read 0. `wr_sel_i`=0 writes it.
- R3: Source select 00 gives one count every 12 clocks (6 when `clk6_mode_i`=1), and 01 gives one every 4 clocks (2). The first count comes that many clocks after counting is enabled. The prescaler restarts whenever counting is disabled or a non-prescaled source is selected. A prescale phase at or past a newly selected ratio gives a count on the next clock.
- R4: The counter holds its value while the run bit (control bit 6) is 0.
- R5: With idle control 1 and `idle_i` high, the counter holds and the prescaler restarts. With idle control 0, `idle_i` has no effect.
- R6: Source select 10 advances the counter once per clock in which `t0_ovf_i` is high.
- R7: Source select 11 advances the counter once per rising edge of `ext_pin_i`. The increment shows two clocks after the edge at which the new pin level is first sampled. The pin is held at least 4 clocks per level.
- R8: The counter wraps from all ones to 0, and that same clock sets the overflow flag (control bit 7).
- R9: Writing the control register (`wr_sel_i`=1) sets or clears bits 7, 6 and 4:0 from the data, and bit 5 reads 0. A hardware set in the same clock as a software clear leaves the flag set.
- R10: A high `mod_evt_i[k]` sets control bit k (k = 0..4) at the next clock. The bit stays set until software writes a 0 to it.
- R11: `irq_o` is high when the overflow flag and the overflow interrupt enable are both 1, or when any module flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | oscillator clock |
| rst_n | input | 1 | active-low asynchronous reset |
| clk6_mode_i | input | 1 | 1 selects 6-clock prescale ratios |
| idle_i | input | 1 | core idle indication |
| t0_ovf_i | input | 1 | timer-0 overflow strobe |
| ext_pin_i | input | 1 | asynchronous external count pin |
| mod_evt_i | input | 5 | per-module match/capture strobes |
| wr_en_i | input | 1 | register write strobe |
| wr_sel_i | input | 1 | 0 mode register, 1 control register |
| wr_data_i | input | 8 | write data |
| mode_rd_o | output | 8 | mode register read value |
| ctrl_rd_o | output | 8 | control/status register read value |
| count_o | output | CNT_W | counter value |
| irq_o | output | 1 | combined interrupt request |
| wdog_en_o | output | 1 | watchdog enable for module 4 |

## Verification
The bench builds the block with CNT_W set to 8 instead of 16, so the wrap and the overflow flag can be reached within a few hundred timer-0 strobes and then many times over during the random phase. The prescale ratios keep their default values. Both clock modes are exercised, so each ratio is checked against its exact cycle count.

// File: rtl/pca_timebase.sv
module pca_timebase #(
  parameter int CNT_W  = 16,
  parameter int DIV_A  = 12,
  parameter int DIV_A6 = 6,
  parameter int DIV_B  = 4,
  parameter int DIV_B6 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk6_mode_i,
  input  logic             idle_i,
  input  logic             t0_ovf_i,
  input  logic             ext_pin_i,
  input  logic [4:0]       mod_evt_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       mode_rd_o,
  output logic [7:0]       ctrl_rd_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             wdog_en_o
);
  localparam int PRE_W = $clog2(DIV_A + 1);
  localparam logic [PRE_W-1:0] LIM_A  = PRE_W'(DIV_A - 1);
  localparam logic [PRE_W-1:0] LIM_A6 = PRE_W'(DIV_A6 - 1);
  localparam logic [PRE_W-1:0] LIM_B  = PRE_W'(DIV_B - 1);
  localparam logic [PRE_W-1:0] LIM_B6 = PRE_W'(DIV_B6 - 1);

  logic idle_ctl_q, wdog_q, ovf_ie_q, run_q, ovf_flag_q;
  logic [1:0] src_q;
  logic [4:0] mflag_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0] ext_q;

  logic wr_mode, wr_ctrl, cnt_en, pre_use, pre_hit, pulse, wrap;
  logic [PRE_W-1:0] lim;

  assign wr_mode = wr_en_i && !wr_sel_i;
  assign wr_ctrl = wr_en_i && wr_sel_i;
  assign cnt_en  = run_q && !(idle_ctl_q && idle_i);
  assign pre_use = cnt_en && !src_q[1];
  assign lim     = src_q[0] ? (clk6_mode_i ? LIM_B6 : LIM_B)
                            : (clk6_mode_i ? LIM_A6 : LIM_A);
  assign pre_hit = pre_use && (pre_q >= lim);

  always_comb begin
    unique case (src_q)
      2'b00, 2'b01: pulse = pre_hit;
      2'b10:        pulse = cnt_en && t0_ovf_i;
      default:      pulse = cnt_en && ext_q[1] && !ext_q[2];
    endcase
  end

  assign wrap = pulse && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= {ext_q[1:0], ext_pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (!pre_use) pre_q <= '0;
    else if (pre_hit)  pre_q <= '0;
    else               pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (pulse) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_ctl_q <= 1'b0;
      wdog_q     <= 1'b0;
      src_q      <= 2'b00;
      ovf_ie_q   <= 1'b0;
    end else if (wr_mode) begin
      idle_ctl_q <= wr_data_i[7];
      wdog_q     <= wr_data_i[6];
      src_q      <= wr_data_i[2:1];
      ovf_ie_q   <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag_q <= 1'b0;
      run_q      <= 1'b0;
      mflag_q    <= '0;
    end else begin
      ovf_flag_q <= wrap | (wr_ctrl ? wr_data_i[7] : ovf_flag_q);
      run_q      <= wr_ctrl ? wr_data_i[6] : run_q;
      mflag_q    <= mod_evt_i | (wr_ctrl ? wr_data_i[4:0] : mflag_q);
    end
  end

  assign mode_rd_o = {idle_ctl_q, wdog_q, 3'b000, src_q, ovf_ie_q};
  assign ctrl_rd_o = {ovf_flag_q, run_q, 1'b0, mflag_q};
  assign count_o   = cnt_q;
  assign wdog_en_o = wdog_q;
  assign irq_o     = (ovf_flag_q && ovf_ie_q) || (|mflag_q);
endmodule

// File: rtl/pca_timebase_chk.sv
module pca_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_i,
  input logic [4:0]       mod_evt_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [7:0]       mode_rd_o,
  input logic [7:0]       ctrl_rd_o,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_o
);
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + 1'b1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd_o[6] |=> $stable(count_o));

  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd_o[7] && idle_i) |=> $stable(count_o));

  assert_wrap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count_o) ##1 (count_o == '0)) |-> ctrl_rd_o[7]);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd_o[7] && !(wr_en_i && wr_sel_i)) |=> ctrl_rd_o[7]);

  assert_event_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_evt_i != 5'b0) |=> irq_o);

  assert_event_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mod_evt_i[0] |=> ctrl_rd_o[0]);
endmodule

bind pca_timebase pca_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .mod_evt_i(mod_evt_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .mode_rd_o(mode_rd_o),
  .ctrl_rd_o(ctrl_rd_o), .count_o(count_o), .irq_o(irq_o)
);

// File: tb/pca_timebase_tb.sv
module pca_timebase_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk6 = 0, idle = 0, t0 = 0, pin = 0, wr_en = 0, wr_sel = 0;
  logic [4:0] evt = '0;
  logic [7:0] wd = '0, mode_rd, ctrl_rd;
  logic [W-1:0] cnt;
  logic irq, wdog;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  pca_timebase #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk6_mode_i(clk6), .idle_i(idle), .t0_ovf_i(t0),
    .ext_pin_i(pin), .mod_evt_i(evt), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wd), .mode_rd_o(mode_rd), .ctrl_rd_o(ctrl_rd), .count_o(cnt),
    .irq_o(irq), .wdog_en_o(wdog));

  logic m_idlec = 0, m_wd = 0, m_ie = 0, m_cf = 0, m_run = 0;
  logic [1:0] m_sel = 0;
  logic [4:0] m_fl = 0;
  logic [W-1:0] m_cnt = 0;
  int m_pre = 0;
  logic [2:0] m_ext = 0;

  function automatic int ratio(logic [1:0] s, logic c6);
    if (s[0]) return c6 ? 2 : 4;
    return c6 ? 6 : 12;
  endfunction

  function automatic logic [7:0] exp_mode();
    return {m_idlec, m_wd, 3'b000, m_sel, m_ie};
  endfunction

  function automatic logic [7:0] exp_ctrl();
    return {m_cf, m_run, 1'b0, m_fl};
  endfunction

  function automatic logic exp_irq();
    return (m_cf && m_ie) || (m_fl != 0);
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic en, p, wm, wc;
    int nxt_pre;
    en = m_run && !(m_idlec && idle);
    if (!m_sel[1]) p = en && (m_pre >= ratio(m_sel, clk6) - 1);
    else if (m_sel == 2'b10) p = en && t0;
    else p = en && m_ext[1] && !m_ext[2];
    nxt_pre = (en && !m_sel[1]) ? (p ? 0 : m_pre + 1) : 0;
    wm = wr_en && !wr_sel;
    wc = wr_en && wr_sel;
    m_cf  = (p && (&m_cnt)) | (wc ? wd[7] : m_cf);
    m_run = wc ? wd[6] : m_run;
    m_fl  = evt | (wc ? wd[4:0] : m_fl);
    if (wm) begin
      m_idlec = wd[7]; m_wd = wd[6]; m_sel = wd[2:1]; m_ie = wd[0];
    end
    if (p) m_cnt = m_cnt + 1'b1;
    m_pre = nxt_pre;
    m_ext = {m_ext[1:0], pin};
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R4", 16'(cnt), 16'(m_cnt));
    chk("R9", 16'(ctrl_rd), 16'(exp_ctrl()));
    chk("R2", 16'(mode_rd), 16'(exp_mode()));
    chk("R11", 16'(irq), 16'(exp_irq()));
    chk("R2", 16'(wdog), 16'(m_wd));
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wd = d;
    cyc();
    wr_en = 0; wd = '0;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  logic done = 0;
  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] c0;
    int hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", 16'(ctrl_rd), 0); chk("R1", 16'(mode_rd), 0);
    chk("R1", 16'(cnt), 0); chk("R1", 16'(irq), 0); chk("R1", 16'(wdog), 0);
    rst_n = 1;
    cyc();

    // R2: reserved bits read 0, watchdog enable follows bit 6
    wr(0, 8'hFF);
    chk("R2", 16'(mode_rd), 16'h00C7);
    chk("R2", 16'(wdog), 1);
    wr(0, 8'h00);

    // R3: select 00, 12-clock mode
    wr(1, 8'h40);
    c0 = cnt;
    run_n(11); chk("R3", 16'(cnt), 16'(c0));
    run_n(1);  chk("R3", 16'(cnt), 16'(c0 + 1));
    run_n(24); chk("R3", 16'(cnt), 16'(c0 + 3));
    // R3: select 01, 6-clock mode
    clk6 = 1; wr(0, 8'h02); run_n(20); chk("R3", 16'(cnt), 16'(m_cnt));
    clk6 = 0; run_n(20); chk("R3", 16'(cnt), 16'(m_cnt));

    // R4: stop
    wr(1, 8'h00); c0 = cnt; run_n(30); chk("R4", 16'(cnt), 16'(c0));

    // R6: timer-0 strobes
    wr(0, 8'h04); wr(1, 8'h40); c0 = cnt;
    for (int i = 0; i < 10; i++) begin t0 = (i % 2 == 0); cyc(); end
    t0 = 0; cyc();
    chk("R6", 16'(cnt), 16'(c0 + 5));

    // R5: idle gating on, then idle without gating
    wr(0, 8'h84); idle = 1; c0 = cnt; t0 = 1; run_n(5); t0 = 0;
    chk("R5", 16'(cnt), 16'(c0));
    wr(0, 8'h04); t0 = 1; run_n(5); t0 = 0; cyc();
    chk("R5", 16'(cnt), 16'(c0 + 5)); idle = 0;

    // R7: external pin, two flops then edge
    wr(0, 8'h06); run_n(4); c0 = cnt;
    pin = 1; cyc(); cyc(); chk("R7", 16'(cnt), 16'(c0));
    cyc(); chk("R7", 16'(cnt), 16'(c0 + 1));
    run_n(4); pin = 0; run_n(4); pin = 1; run_n(4);
    chk("R7", 16'(cnt), 16'(c0 + 2)); pin = 0; run_n(4);

    // R8: wrap via timer-0
    wr(1, 8'h40); wr(0, 8'h05); t0 = 1;
    for (int i = 0; i < 300 && !m_cf; i++) cyc();
    t0 = 0; cyc();
    chk("R8", 16'(ctrl_rd[7]), 1);
    chk("R11", 16'(irq), 1);

    // R10 and R9: event flags, hardware set beats software clear
    evt = 5'b10100; cyc(); evt = 0; cyc();
    chk("R10", 16'(ctrl_rd[4:0]), 16'b10100);
    evt = 5'b00001; wr(1, 8'h40); evt = 0;
    chk("R9", 16'(ctrl_rd), 16'h0041);
    wr(1, 8'h40);
    chk("R9", 16'(ctrl_rd), 16'h0040);
    chk("R11", 16'(irq), 0);

    // constrained random phase
    hold = 0;
    for (int i = 0; i < 20000; i++) begin
      wr_en = ($urandom % 10) == 0;
      wr_sel = $urandom % 2;
      wd = $urandom;
      if (wr_sel && ($urandom % 8) != 0) wd[6] = 1;
      if (wr_sel) wd[7] = ($urandom % 4) == 0;
      t0 = ($urandom % 3) == 0;
      idle = ($urandom % 5) == 0;
      for (int k = 0; k < 5; k++) evt[k] = ($urandom % 40) == 0;
      if (($urandom % 500) == 0) clk6 = ~clk6;
      hold++;
      if (hold >= 4 && ($urandom % 3) == 0) begin pin = ~pin; hold = 0; end
      cyc();
    end
    wr_en = 0; evt = 0; t0 = 0; idle = 0;
    cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule